// File: doc/BRIEF.md
# PLL Relock Reprogramming Sequencer

This block changes the feedback, reference and post divider coefficients of a clock PLL in the case where the output frequency cannot be slid gradually to the new value. The PLL must be stopped and relocked instead. The sequencer does this in a fixed, safe order. It first halves the output through the output divider, so that the later jump to bypass and back is split into two smaller steps. It then routes the output to bypass and stops the PLL. It writes the new coefficient word while the PLL is stopped. It restarts the PLL with lock detection turned on and waits for lock. After lock it routes the output back to the VCO, lets it settle, and returns the output divider to full rate.

A controller pulses `start` with the new coefficients on `m_in`, `n_in` and `pl_in`. It then watches `done`. The `timeout` flag tells it whether lock was reached. Every change to the output divider is written twice on consecutive cycles, so that the divider changes linearly. All timing comes from one shared microsecond timer, which is built from a prescaler of `US_CYCLES` clock cycles.

Top module: `pll_relock_seq`

## Requirements
- R1: `start` is sampled high while the block is idle. On that same edge `div_half` goes to 1 (output divided by 2) and `div_wr` pulses. `div_wr` is high for exactly two consecutive cycles.
- R2: The settle wait after the second halving write ends 2*US_CYCLES+1 cycles after it begins. On that edge `vco_sel` drops to 0 (bypass). On the following edge `pll_en` drops to 0, so bypass always comes before disable.
- R3: One edge after `pll_en` drops, `coef_wr` pulses for one cycle while `pll_en` is 0. During that pulse `coef_word` holds M in bits [7:0], N in bits [15:8] and PL in bits [21:16], with every other bit 0.
- R4: `lkdet_off` resets to 1. On the edge after the coefficient write, `pll_en` rises to 1 and `lkdet_off` clears to 0 together.
- R5: In the lock wait, `lock` is sampled on each edge, starting one edge after `pll_en` rises. The first edge that sees `lock` high sets `vco_sel` to 1. This holds even on the very first edge of the wait.
- R6: After `vco_sel` rises there is a second wait of 2*US_CYCLES+1 cycles. `div_half` then returns to 0, again with a two-cycle `div_wr` pulse. One cycle after the pulse ends, `done` pulses for one cycle and `timeout` stays 0.
- R7: If `lock` has not been seen after 300*US_CYCLES+1 edges of waiting, `timeout` and `done` both rise. `done` lasts one cycle. The divider stays halved and `vco_sel` stays at bypass. `timeout` holds until the next accepted `start` clears it.
- R8: After reset: `div_half`=0, `div_wr`=0, `pll_en`=0, `lkdet_off`=1, `vco_sel`=0, `coef_wr`=0, `coef_word`=0, `done`=0, `timeout`=0.
- R9: The coefficients are captured on the edge that accepts `start`. A `start` pulse or a coefficient change during a running sequence has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a relock sequence (sampled when idle) |
| m_in | input | M_W | New reference divider M |
| n_in | input | N_W | New feedback divider N |
| pl_in | input | PL_W | New post divider code PL |
| lock | input | 1 | Lock indication from the PLL |
| div_half | output | 1 | Output divider select: 1 = divide by 2, 0 = divide by 1 |
| div_wr | output | 1 | Output divider write strobe |
| pll_en | output | 1 | PLL enable |
| lkdet_off | output | 1 | Lock detection disable |
| vco_sel | output | 1 | Output source: 1 = VCO, 0 = bypass |
| coef_wr | output | 1 | Coefficient register write strobe |
| coef_word | output | WORD_W | Packed coefficient word |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | Lock was not reached; held until next start |

## Verification
On every cycle, the assertions check the ordering rules. Bypass comes before disable. Coefficients are written only while the PLL is stopped. Enable and lock-detect clearing happen together. The VCO is selected only after lock and while the output is halved. Divider writes always come in pairs. `done` is a single pulse, and a timeout leaves the divider halved. The exact cycle counts of the two settle waits and of the lock timeout can only be shown by the bench's scenarios. The same holds for packing of the captured coefficients, for ignoring a start while busy, and for `timeout` persisting until the next start. The bench compares all outputs on every clock against its reference model.

// File: rtl/pll_relock_pkg.sv
package pll_relock_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HALF2,
    ST_SETTLE_A,
    ST_OFF,
    ST_LOAD,
    ST_ON,
    ST_LOCKWAIT,
    ST_SETTLE_B,
    ST_FULL2,
    ST_FINISH
  } relock_state_t;
endpackage

// File: rtl/pll_us_timer.sv
// Shared microsecond timer: a cycle prescaler feeding a microsecond counter.
// Counting stops once the target is reached; clr zeroes both stages.
module pll_us_timer #(
  parameter int US_CYCLES = 50,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] target,
  output logic             expired
);
  localparam int PRE_W = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] us_q;

  assign expired = (us_q == target);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (!expired) begin
      if (pre_q == PRE_W'(US_CYCLES - 1)) begin
        pre_q <= '0;
        us_q  <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_coef_pack.sv
// Places each coefficient at its own offset inside the register word.
module pll_coef_pack #(
  parameter int M_W    = 8,
  parameter int N_W    = 8,
  parameter int PL_W   = 6,
  parameter int M_LSB  = 0,
  parameter int N_LSB  = 8,
  parameter int PL_LSB = 16,
  parameter int WORD_W = 32
) (
  input  logic [M_W-1:0]    m,
  input  logic [N_W-1:0]    n,
  input  logic [PL_W-1:0]   pl,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word                   = '0;
    word[M_LSB  +: M_W]    = m;
    word[N_LSB  +: N_W]    = n;
    word[PL_LSB +: PL_W]   = pl;
  end
endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
  import pll_relock_pkg::*;
#(
  parameter int US_CYCLES = 50,
  parameter int SETTLE_US = 2,
  parameter int LOCK_US   = 300,
  parameter int M_W       = 8,
  parameter int N_W       = 8,
  parameter int PL_W      = 6,
  parameter int M_LSB     = 0,
  parameter int N_LSB     = 8,
  parameter int PL_LSB    = 16,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [M_W-1:0]    m_in,
  input  logic [N_W-1:0]    n_in,
  input  logic [PL_W-1:0]   pl_in,
  input  logic              lock,
  output logic              div_half,
  output logic              div_wr,
  output logic              pll_en,
  output logic              lkdet_off,
  output logic              vco_sel,
  output logic              coef_wr,
  output logic [WORD_W-1:0] coef_word,
  output logic              done,
  output logic              timeout
);
  localparam int MAX_US = (LOCK_US > SETTLE_US) ? LOCK_US : SETTLE_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  relock_state_t state;
  logic [M_W-1:0]    m_q;
  logic [N_W-1:0]    n_q;
  logic [PL_W-1:0]   pl_q;
  logic [WORD_W-1:0] packed_w;
  logic              in_wait, leave_wait, tmr_clr, tmr_exp;
  logic [US_W-1:0]   tmr_target;

  // Timer is held clear outside waits and on the edge that leaves one
  always_comb begin
    in_wait    = (state == ST_SETTLE_A) || (state == ST_LOCKWAIT) || (state == ST_SETTLE_B);
    leave_wait = tmr_exp || ((state == ST_LOCKWAIT) && lock);
    tmr_clr    = !in_wait || leave_wait;
    tmr_target = (state == ST_LOCKWAIT) ? US_W'(LOCK_US) : US_W'(SETTLE_US);
  end

  pll_us_timer #(.US_CYCLES(US_CYCLES), .CNT_W(US_W)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .target(tmr_target), .expired(tmr_exp)
  );

  pll_coef_pack #(
    .M_W(M_W), .N_W(N_W), .PL_W(PL_W),
    .M_LSB(M_LSB), .N_LSB(N_LSB), .PL_LSB(PL_LSB), .WORD_W(WORD_W)
  ) u_pack (
    .m(m_q), .n(n_q), .pl(pl_q), .word(packed_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      m_q       <= '0;
      n_q       <= '0;
      pl_q      <= '0;
      div_half  <= 1'b0;
      div_wr    <= 1'b0;
      pll_en    <= 1'b0;
      lkdet_off <= 1'b1;
      vco_sel   <= 1'b0;
      coef_wr   <= 1'b0;
      coef_word <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      div_wr  <= 1'b0;
      coef_wr <= 1'b0;
      done    <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          m_q      <= m_in;
          n_q      <= n_in;
          pl_q     <= pl_in;
          timeout  <= 1'b0;
          div_half <= 1'b1;
          div_wr   <= 1'b1;
          state    <= ST_HALF2;
        end
        ST_HALF2: begin
          div_wr <= 1'b1;
          state  <= ST_SETTLE_A;
        end
        ST_SETTLE_A: if (tmr_exp) begin
          vco_sel <= 1'b0;
          state   <= ST_OFF;
        end
        ST_OFF: begin
          pll_en <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          coef_wr   <= 1'b1;
          coef_word <= packed_w;
          state     <= ST_ON;
        end
        ST_ON: begin
          pll_en    <= 1'b1;
          lkdet_off <= 1'b0;
          state     <= ST_LOCKWAIT;
        end
        ST_LOCKWAIT: begin
          if (lock) begin
            vco_sel <= 1'b1;
            state   <= ST_SETTLE_B;
          end else if (tmr_exp) begin
            timeout <= 1'b1;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_SETTLE_B: if (tmr_exp) begin
          div_half <= 1'b0;
          div_wr   <= 1'b1;
          state    <= ST_FULL2;
        end
        ST_FULL2: begin
          div_wr <= 1'b1;
          state  <= ST_FINISH;
        end
        ST_FINISH: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1/R6: divider writes come in pairs, with a stable setting across the pair
  p_div_pair_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(div_wr) |=> div_wr && $stable(div_half));
  p_div_no_third_r6: assert property (@(posedge clk) disable iff (rst)
    (div_wr && $past(div_wr)) |=> !div_wr);
  // R2: the output is already in bypass when the PLL is disabled
  p_bypass_first_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en) |-> !vco_sel && !$past(vco_sel));
  // R3: coefficients only written with the PLL stopped
  p_coef_off_r3: assert property (@(posedge clk) disable iff (rst)
    coef_wr |-> !pll_en);
  // R4: lock detection is on whenever the PLL is restarted
  p_lkdet_on_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> !lkdet_off);
  // R5: VCO selected only after lock was seen, still halved and enabled
  p_vco_after_lock_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vco_sel) |-> $past(lock) && pll_en && div_half);
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: abort reports done and leaves the divider halved
  p_abort_halved_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> done && div_half && !vco_sel);
endmodule

// File: tb/pll_relock_seq_test.sv
module pll_relock_seq_test;
  localparam int US = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] m_in = '0;
  logic [7:0] n_in = '0;
  logic [5:0] pl_in = '0;
  logic lock = 1'b0;
  logic div_half, div_wr, pll_en, lkdet_off, vco_sel, coef_wr, done, timeout;
  logic [31:0] coef_word;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  logic [31:0] last_word = '0;

  always #10 clk = ~clk;

  pll_relock_seq uut (
    .clk(clk), .rst(rst), .start(start), .m_in(m_in), .n_in(n_in), .pl_in(pl_in),
    .lock(lock), .div_half(div_half), .div_wr(div_wr), .pll_en(pll_en),
    .lkdet_off(lkdet_off), .vco_sel(vco_sel), .coef_wr(coef_wr),
    .coef_word(coef_word), .done(done), .timeout(timeout)
  );

  // Reference model: behavioural step list with integer countdowns
  logic e_half, e_wr, e_en, e_lkoff, e_vco, e_cwr, e_done, e_to;
  logic [31:0] e_word;
  logic [7:0] cm, cn;
  logic [5:0] cpl;
  int step = 0;
  int wl = 0;

  always @(posedge clk) begin
    e_wr = 0; e_cwr = 0; e_done = 0;
    if (rst) begin
      step = 0; e_half = 0; e_en = 0; e_lkoff = 1; e_vco = 0; e_word = 0; e_to = 0;
    end else begin
      case (step)
        0: if (start) begin
             cm = m_in; cn = n_in; cpl = pl_in;
             e_half = 1; e_wr = 1; e_to = 0; step = 1;
           end
        1: begin e_wr = 1; wl = 2*US; step = 2; end
        2: if (wl == 0) begin e_vco = 0; step = 3; end else wl--;
        3: begin e_en = 0; step = 4; end
        4: begin e_cwr = 1; e_word = {10'd0, cpl, cn, cm}; step = 5; end
        5: begin e_en = 1; e_lkoff = 0; wl = 300*US; step = 6; end
        6: if (lock) begin e_vco = 1; wl = 2*US; step = 7; end
           else if (wl == 0) begin e_to = 1; e_done = 1; step = 0; end
           else wl--;
        7: if (wl == 0) begin e_half = 0; e_wr = 1; step = 8; end else wl--;
        8: begin e_wr = 1; step = 9; end
        default: begin e_done = 1; step = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(div_half === e_half, "R1 div_half", 32'(div_half), 32'(e_half));
    chk(div_wr === e_wr, "R1 div_wr", 32'(div_wr), 32'(e_wr));
    chk(vco_sel === e_vco, "R2 vco_sel", 32'(vco_sel), 32'(e_vco));
    chk(pll_en === e_en, "R2 pll_en", 32'(pll_en), 32'(e_en));
    chk(coef_wr === e_cwr, "R3 coef_wr", 32'(coef_wr), 32'(e_cwr));
    chk(coef_word === e_word, "R3 coef_word", coef_word, e_word);
    chk(lkdet_off === e_lkoff, "R4 lkdet_off", 32'(lkdet_off), 32'(e_lkoff));
    chk(done === e_done, "R6 done", 32'(done), 32'(e_done));
    chk(timeout === e_to, "R7 timeout", 32'(timeout), 32'(e_to));
    if (coef_wr) last_word = coef_word;
  end

  // lock_after < 0: never lock. poke: extra start with other values mid-run.
  task automatic run(input logic [7:0] m, input logic [7:0] n, input logic [5:0] pl,
                     input int lock_after, input bit poke);
    @(negedge clk);
    m_in = m; n_in = n; pl_in = pl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      m_in = 8'hEE; n_in = 8'hDD; pl_in = 6'h3F; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (pll_en) @(negedge clk);
    while (!pll_en) @(negedge clk);
    if (lock_after >= 0) begin
      repeat (lock_after) @(negedge clk);
      lock = 1'b1;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    lock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R8 reset state
    chk(pll_en == 0 && div_half == 0 && vco_sel == 0, "R8 reset outputs", {29'd0, pll_en, div_half, vco_sel}, 0);
    chk(lkdet_off == 1, "R8 lkdet_off", 32'(lkdet_off), 1);
    chk(coef_word == 0 && done == 0 && timeout == 0, "R8 word/flags", coef_word, 0);

    run(8'h05, 8'h7A, 6'h03, 37, 1'b0);
    chk(last_word == 32'h0003_7A05, "R3 packing", last_word, 32'h0003_7A05);
    chk(timeout == 0 && vco_sel == 1 && div_half == 0, "R6 success end", {29'd0, timeout, vco_sel, div_half}, 3'b010);
    chk(lkdet_off == 0, "R4 cleared", 32'(lkdet_off), 0);

    run(8'h01, 8'hFF, 6'h2A, 0, 1'b0);   // R5 lock on first wait edge
    chk(last_word == 32'h002A_FF01, "R5 immediate lock word", last_word, 32'h002A_FF01);
    chk(vco_sel == 1 && timeout == 0, "R5 immediate lock", {30'd0, vco_sel, timeout}, 2'b10);

    run(8'h11, 8'h22, 6'h15, -1, 1'b0);  // R7 timeout
    chk(timeout == 1 && div_half == 1 && vco_sel == 0, "R7 abort state", {29'd0, timeout, div_half, vco_sel}, 3'b110);
    repeat (25) @(negedge clk);
    chk(timeout == 1, "R7 timeout held", 32'(timeout), 1);

    run(8'h33, 8'h44, 6'h01, 5, 1'b1);   // R9 start while busy ignored
    chk(last_word == 32'h0001_4433, "R9 captured coefs", last_word, 32'h0001_4433);
    chk(timeout == 0, "R7 cleared by start", 32'(timeout), 0);
    repeat (5) @(negedge clk);
    chk(done == 0 && div_wr == 0 && coef_wr == 0, "R9 idle after poke", {29'd0, done, div_wr, coef_wr}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule